// File: doc/BRIEF.md
# Trunked Destination Port Selector

This block picks the output port for each packet in a packet switch. A routing table holds one entry per destination ID. Each entry has a member mask, where every set bit marks a port that reaches that destination, and a static port number. A mask with several bits set forms a trunk. For a trunked destination, successive packets are spread over the member ports in round-robin order. Each destination keeps its own rotation pointer.

A per-packet bypass flag skips the trunk and sends the packet to the static port of the entry. A routing program uses this to pin each source/destination pair to a separate link. For example, four destinations can be tied to four distinct ports. A destination whose mask is empty reports a no-route error unless the request bypasses the trunk. The table write port, the request and the response all run in one clock domain. The response is registered and appears one clock after its request.

Top module: `trunk_port_select`

## Requirements
- R1: After reset `rsp_valid` is 0, every table entry has an empty member mask and static port 0, and every rotation pointer names the highest port, NUM_PORTS-1.
- R2: `rsp_valid` equals `req_valid` of the previous clock, and a response belongs to the request of the previous clock.
- R3: For a trunked request (`req_bypass`=0, mask non-empty), `rsp_port` is a port whose bit is set in the entry's member mask, and `rsp_noroute` is 0.
- R4: A trunked request is granted the first set mask bit strictly after the destination's pointer, searching upward and wrapping past NUM_PORTS-1 to 0. The pointer then holds the granted port. So the first grant after reset or after a write is the lowest set bit.
- R5: With `req_bypass`=1, `rsp_port` is the entry's static port and `rsp_noroute` is 0, even when the mask is empty. The destination's pointer is not moved.
- R6: A request with `req_bypass`=0 to an entry whose mask is all zeros gives `rsp_noroute`=1 and `rsp_port`=0, and leaves the pointer unchanged.
- R7: A table write at one clock is seen by requests from the next clock on. A request in the same clock as a write to its destination uses the old entry.
- R8: A table write sets that destination's pointer to NUM_PORTS-1, so the next trunked grant is the lowest set bit of the new mask.
- R9: Pointers are per destination. Requests to one destination never change the rotation of another.
- R10: An entry with exactly one mask bit set always returns that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_dest | input | DEST_W (8) | Destination ID of the entry written |
| wr_mask | input | NUM_PORTS (8) | Trunk member mask, bit i set means port i reaches the destination |
| wr_static | input | PORT_W (3) | Static port used when a request bypasses the trunk |
| req_valid | input | 1 | Lookup request strobe |
| req_dest | input | DEST_W (8) | Destination ID to route |
| req_bypass | input | 1 | 1 = use the static port, 0 = use the trunk |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_port | output | PORT_W (3) | Chosen output port |
| rsp_noroute | output | 1 | Trunked request hit an empty mask |

## Verification
A corrupted rotation pointer shows up on the very next trunked response to that destination. Because the grant sequence is fully determined, the bench sees it as a wrong port at once, for example a repeated port instead of the next member. A wrong pointer on another destination shows up only when that destination is next requested. Interleaved requests to several destinations expose such crosstalk within two responses. A stale or early table read shows up as a wrong port or a wrong no-route flag on the response one clock after the request that lands in the same cycle as a write.

// File: rtl/trunk_sel_pkg.sv
package trunk_sel_pkg;
   // Width of a port index for a given port count (at least 1 bit).
   function automatic int port_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/trunk_sel_rr_pick.sv
// Round-robin member search: first set bit strictly after 'last', wrapping.
module trunk_sel_rr_pick #(
   parameter int NUM_PORTS = 8,
   localparam int PORT_W = trunk_sel_pkg::port_bits(NUM_PORTS)
) (
   input  logic [NUM_PORTS-1:0] mask,
   input  logic [PORT_W-1:0]    last,
   output logic [PORT_W-1:0]    pick,
   output logic                 hit
);
   always_comb begin
      pick = '0;
      hit  = 1'b0;
      for (int off = 1; off <= NUM_PORTS; off++) begin
         int unsigned idx;
         idx = (int'(last) + off) % NUM_PORTS;
         if (!hit && mask[idx]) begin
            hit  = 1'b1;
            pick = PORT_W'(idx);
         end
      end
   end

   always_comb begin
      if (hit) assert_pick_member_R3: assert (mask[pick]);
      else     assert_miss_empty_R6: assert (mask == '0);
   end
endmodule

// File: rtl/trunk_sel_table.sv
// Routing entries plus one rotation pointer per destination.
module trunk_sel_table #(
   parameter int NUM_PORTS = 8,
   parameter int DEST_W    = 8,
   localparam int PORT_W   = trunk_sel_pkg::port_bits(NUM_PORTS),
   localparam int NUM_DEST = 1 << DEST_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DEST_W-1:0]    wr_dest,
   input  logic [NUM_PORTS-1:0] wr_mask,
   input  logic [PORT_W-1:0]    wr_static,
   input  logic [DEST_W-1:0]    rd_dest,
   output logic [NUM_PORTS-1:0] rd_mask,
   output logic [PORT_W-1:0]    rd_static,
   output logic [PORT_W-1:0]    rd_last,
   input  logic                 adv_en,
   input  logic [DEST_W-1:0]    adv_dest,
   input  logic [PORT_W-1:0]    adv_port
);
   localparam logic [PORT_W-1:0] PTR_INIT = PORT_W'(NUM_PORTS - 1);

   logic [NUM_PORTS-1:0] mask_q   [NUM_DEST];
   logic [PORT_W-1:0]    static_q [NUM_DEST];
   logic [PORT_W-1:0]    ptr_q    [NUM_DEST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < NUM_DEST; d++) begin
            mask_q[d]   <= '0;
            static_q[d] <= '0;
            ptr_q[d]    <= PTR_INIT;
         end
      end else begin
         if (adv_en) ptr_q[adv_dest] <= adv_port;
         if (wr_en) begin
            mask_q[wr_dest]   <= wr_mask;
            static_q[wr_dest] <= wr_static;
            ptr_q[wr_dest]    <= PTR_INIT;
         end
      end
   end

   assign rd_mask   = mask_q[rd_dest];
   assign rd_static = static_q[rd_dest];
   assign rd_last   = ptr_q[rd_dest];

   for (genvar d = 0; d < NUM_DEST; d++) begin : g_ptr_chk
      assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_dest == DEST_W'(d)) |=> (ptr_q[d] == PTR_INIT));
      assert_ptr_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (adv_en && adv_dest == DEST_W'(d) && !(wr_en && wr_dest == DEST_W'(d)))
         |=> (ptr_q[d] == $past(adv_port)));
      assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!(adv_en && adv_dest == DEST_W'(d)) && !(wr_en && wr_dest == DEST_W'(d)))
         |=> $stable(ptr_q[d]));
   end
endmodule

// File: rtl/trunk_port_select.sv
module trunk_port_select #(
   parameter int NUM_PORTS = 8,
   parameter int DEST_W    = 8,
   localparam int PORT_W   = trunk_sel_pkg::port_bits(NUM_PORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DEST_W-1:0]    wr_dest,
   input  logic [NUM_PORTS-1:0] wr_mask,
   input  logic [PORT_W-1:0]    wr_static,
   input  logic                 req_valid,
   input  logic [DEST_W-1:0]    req_dest,
   input  logic                 req_bypass,
   output logic                 rsp_valid,
   output logic [PORT_W-1:0]    rsp_port,
   output logic                 rsp_noroute
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("trunk_port_select: NUM_PORTS must be at least 2");
   end
   if (DEST_W < 1 || DEST_W > 10) begin : g_bad_dest
      $error("trunk_port_select: DEST_W must be 1..10");
   end

   logic [NUM_PORTS-1:0] lk_mask;
   logic [PORT_W-1:0]    lk_static;
   logic [PORT_W-1:0]    lk_last;
   logic [PORT_W-1:0]    rr_pick;
   logic                 rr_hit;
   logic                 grant;

   trunk_sel_table #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_dest   (wr_dest),
      .wr_mask   (wr_mask),
      .wr_static (wr_static),
      .rd_dest   (req_dest),
      .rd_mask   (lk_mask),
      .rd_static (lk_static),
      .rd_last   (lk_last),
      .adv_en    (grant),
      .adv_dest  (req_dest),
      .adv_port  (rr_pick)
   );

   trunk_sel_rr_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
      .mask (lk_mask),
      .last (lk_last),
      .pick (rr_pick),
      .hit  (rr_hit)
   );

   assign grant = req_valid && !req_bypass && rr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_port    <= '0;
         rsp_noroute <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_noroute <= req_valid && !req_bypass && !rr_hit;
         if (!req_valid)     rsp_port <= '0;
         else if (req_bypass) rsp_port <= lk_static;
         else if (rr_hit)     rsp_port <= rr_pick;
         else                 rsp_port <= '0;
      end
   end

   assert_rsp_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_valid == $past(req_valid)));
   assert_noroute_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_noroute |-> rsp_valid);
   assert_trunk_member_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_bypass && lk_mask != '0)
      |=> (!rsp_noroute && (($past(lk_mask) >> rsp_port) & NUM_PORTS'(1)) != '0));
   assert_empty_noroute_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_bypass && lk_mask == '0) |=> (rsp_noroute && rsp_port == '0));
   assert_bypass_static_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bypass) |=> (!rsp_noroute && rsp_port == $past(lk_static)));
endmodule

// File: tb/trunk_port_select_bench.sv
module trunk_port_select_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;
   localparam int DW = 8;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_dest = '0;
   logic [NP-1:0] wr_mask = '0;
   logic [PW-1:0] wr_static = '0;
   logic          req_valid = 1'b0;
   logic [DW-1:0] req_dest = '0;
   logic          req_bypass = 1'b0;
   logic          rsp_valid;
   logic [PW-1:0] rsp_port;
   logic          rsp_noroute;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trunk_port_select #(.NUM_PORTS(NP), .DEST_W(DW)) u_trunk_port_select (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_dest(wr_dest), .wr_mask(wr_mask), .wr_static(wr_static),
      .req_valid(req_valid), .req_dest(req_dest), .req_bypass(req_bypass),
      .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_noroute(rsp_noroute)
   );

   typedef struct packed {
      logic [7:0] dest;
      logic       byp;
      logic [2:0] port;
      logic       nr;
   } vec_t;

   // Entries: d4 mask 0x70 static 2; d5 mask 0x01 static 1;
   //          d9 mask 0x81 static 3; d6 mask 0x00 static 6.
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{8'd4,  1'b0, 3'd4, 1'b0},   // R4 first grant = lowest bit
      '{8'd4,  1'b0, 3'd5, 1'b0},   // R4
      '{8'd9,  1'b0, 3'd0, 1'b0},   // R9 own pointer
      '{8'd4,  1'b0, 3'd6, 1'b0},   // R4
      '{8'd4,  1'b1, 3'd2, 1'b0},   // R5 static, no advance
      '{8'd4,  1'b0, 3'd4, 1'b0},   // R4 wrap, R5 pointer held
      '{8'd9,  1'b0, 3'd7, 1'b0},   // R3
      '{8'd6,  1'b0, 3'd0, 1'b1},   // R6 empty mask
      '{8'd6,  1'b1, 3'd6, 1'b0},   // R5 bypass on empty mask
      '{8'd5,  1'b0, 3'd0, 1'b0},   // R10
      '{8'd5,  1'b0, 3'd0, 1'b0},   // R10
      '{8'd9,  1'b0, 3'd0, 1'b0},   // R4 wrap 7->0
      '{8'd4,  1'b0, 3'd5, 1'b0},   // R9 untouched by others
      '{8'd77, 1'b0, 3'd0, 1'b1}    // R1 unwritten entry is empty
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_entry(input int d, input int m, input int s);
      wr_en = 1'b1; wr_dest = DW'(d); wr_mask = NP'(m); wr_static = PW'(s);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Drive a request; after return the response of that request is on the outputs.
   task automatic request(input int d, input bit b);
      req_valid = 1'b1; req_dest = DW'(d); req_bypass = b;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input int port, input bit nr);
      check(rsp_valid == 1'b1, {req, " valid"}, int'(rsp_valid), 1);
      check(rsp_port == PW'(port), {req, " port"}, int'(rsp_port), port);
      check(rsp_noroute == nr, {req, " noroute"}, int'(rsp_noroute), int'(nr));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(rsp_valid == 1'b0, "R1 reset valid", int'(rsp_valid), 0);
      check(rsp_noroute == 1'b0, "R1 reset noroute", int'(rsp_noroute), 0);
      request(4, 1'b0);
      expect_rsp("R1 empty after reset", 0, 1'b1);
      request(4, 1'b1);
      expect_rsp("R1 static zero after reset", 0, 1'b0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R2 idle", int'(rsp_valid), 0);

      write_entry(4, 'h70, 2);
      write_entry(5, 'h01, 1);
      write_entry(9, 'h81, 3);
      write_entry(6, 'h00, 6);

      for (int i = 0; i < NV; i++) begin
         req_valid = 1'b1; req_dest = VECS[i].dest; req_bypass = VECS[i].byp;
         @(negedge clk);
         expect_rsp($sformatf("R3/R4 vector %0d", i), int'(VECS[i].port), VECS[i].nr);
      end
      req_valid = 1'b0;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R2 valid drops", int'(rsp_valid), 0);

      // R7: write and request to the same destination in one cycle
      wr_en = 1'b1; wr_dest = 8'd6; wr_mask = 8'h08; wr_static = 3'd6;
      req_valid = 1'b1; req_dest = 8'd6; req_bypass = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      expect_rsp("R7 same cycle sees old", 0, 1'b1);
      request(6, 1'b0);
      expect_rsp("R7 next cycle sees new", 3, 1'b0);

      // R8: rewrite d4 (pointer at 5) -> next grant lowest bit 4
      write_entry(4, 'h70, 2);
      request(4, 1'b0);
      expect_rsp("R8 pointer cleared", 4, 1'b0);
      write_entry(4, 'h60, 2);
      request(4, 1'b0);
      expect_rsp("R8 new mask lowest", 5, 1'b0);

      // R5: static pinning, destinations 20..23 to ports 0..3
      for (int k = 0; k < 4; k++) write_entry(20 + k, 'hFF, k);
      for (int k = 0; k < 4; k++) begin
         request(20 + k, 1'b1);
         expect_rsp("R5 static pin", k, 1'b0);
      end
      // R5: bypass left the trunk pointer alone -> lowest bit first
      request(21, 1'b0);
      expect_rsp("R5 pointer untouched", 0, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule